// File: doc/BRIEF.md
# Programmable Decade Time Base Divider

This block is the time base of a counting instrument. A fast reference arrives as a single-cycle enable strobe on the system clock. A fixed prescaler divides it by ten to give a base-rate strobe. A mode input chooses what the programmable divider counts. In time/frequency mode it counts the base-rate strobe. In period/events mode it counts an external, already conditioned strobe. The divider gives one single-cycle output pulse for every N input strobes, where N is a power of ten picked by a 3-bit ratio code.

The divider is a cascade of BCD decade stages. The output is taken from the carry into the stage that the code selects. In period/events mode the top code bit is forced low, so only the four smallest ratios are available there. A hold input parks every stage at nine, so the first input strobe after release produces a pulse straight away. New ratio and mode settings are taken up only when a pulse is produced or while hold is asserted. The running interval is therefore never cut short or stretched by a setting change.

Top module: `decade_timebase`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) clears the prescaler and all decade stages, drives `tb_pulse` low, and takes up the mode and ratio inputs present at that edge.
- R2: With the latched mode at 0 (time/frequency), the divider counts one base strobe per ten `ref_tick` strobes. The base strobe is the 10th, 20th, 30th … `ref_tick` counted since reset. The prescaler keeps running in either mode and during hold.
- R3: With the latched mode at 1 (period/events), the divider counts `ext_tick` strobes, and `ref_tick` has no effect on `tb_pulse`.
- R4: Ratio codes 0, 1, 2 and 3 give one output pulse per 1, 10, 100 and 1000 input strobes. Code 0 turns every input strobe into a pulse.
- R5: In mode 0, ratio codes 4, 5, 6 and 7 give one output pulse per 10^4, 10^5, 10^6 and 10^7 input strobes.
- R6: In mode 1, bit 2 of `ratio_code` is ignored. Code 4+k behaves exactly as code k.
- R7: While `hold` is 1, `tb_pulse` stays low and every decade stage sits at nine. The first input strobe after `hold` returns to 0 produces a pulse.
- R8: `tb_pulse` is high for exactly the one clock cycle after the edge that samples the terminal input strobe. The count restarts from zero after each pulse.
- R9: A change of `ratio_code` or `mode_ext` is taken up only at the edge that produces a pulse, or at an edge where `hold` is 1. Until then the previous ratio and source stay in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Fast reference enable strobe, one cycle per reference period |
| ext_tick | input | 1 | Conditioned external enable strobe |
| mode_ext | input | 1 | 0 selects the time/frequency source, 1 selects the period/events source |
| ratio_code | input | 3 | Decade ratio select, division by 10^code |
| hold | input | 1 | Parks the interval counter at its terminal value |
| tb_pulse | output | 1 | Single-cycle time base output pulse |

## Verification
The hardest situation to reach is a setting change in the middle of a long interval. The old ratio must finish its full count before the new one applies. The bench first parks the divider with hold. It then drives a dense external strobe, changes the code and the mode partway through an interval, and lets an arithmetic model of the decade count predict each pulse cycle. The largest ratios cannot be run to completion in a short run. They are reached through hold: the bench releases hold and checks for an immediate pulse, then runs one full 10^4 interval of base strobes.

// File: rtl/tbd_pkg.sv
// Shared types for the decade time base divider.
// Assumes one system clock; all strobes are single-cycle enables.
package tbd_pkg;

    localparam int unsigned CODE_W    = 3;
    localparam logic [3:0]  DIGIT_MAX = 4'd9;

    typedef logic [3:0] bcd_t;

    typedef enum logic {
        SRC_BASE = 1'b0,
        SRC_EXT  = 1'b1
    } src_e;

endpackage

// File: rtl/tbd_prescaler.sv
// Fixed-ratio prescaler: emits one strobe per PRE_DIV input strobes.
// Assumes in_tick is a single-cycle enable; the output is combinational
// from the count and the current input strobe.
module tbd_prescaler #(
    parameter int unsigned PRE_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_tick,
    output logic out_tick
);

    localparam int unsigned CNT_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PRE_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    assign out_tick = in_tick && (cnt_q == LAST);

    // Count input strobes modulo PRE_DIV.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (in_tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    p_presc_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_presc_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |=> (cnt_q == '0));

endmodule

// File: rtl/tbd_bcd_stage.sv
// One BCD decade of the interval counter.
// Priority: reset, then park at nine, then clear, then increment.
// at_max flags the digit nine so the carry chain can be built outside.
module tbd_bcd_stage
    import tbd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic park,
    input  logic clear,
    input  logic inc,
    output bcd_t digit,
    output logic at_max
);

    bcd_t digit_q;

    assign digit  = digit_q;
    assign at_max = (digit_q == DIGIT_MAX);

    // Update the decade digit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= '0;
        end else if (park) begin
            digit_q <= DIGIT_MAX;
        end else if (clear) begin
            digit_q <= '0;
        end else if (inc) begin
            digit_q <= at_max ? '0 : digit_q + 4'd1;
        end
    end

    p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        digit_q <= DIGIT_MAX);

    p_bcd_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && at_max && !park && !clear) |=> (digit_q == '0));

endmodule

// File: rtl/tbd_cfg.sv
// Holds the configuration in force: the source and the selected decade.
// New inputs are taken up at reset or when load is high. In external mode
// the top code bit is forced low. Codes above N_DECADES clamp to it.
module tbd_cfg
    import tbd_pkg::*;
#(
    parameter int unsigned N_DECADES = 7,
    parameter int unsigned SEL_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              mode_ext,
    input  logic [CODE_W-1:0] ratio_code,
    output src_e              src_q,
    output logic [SEL_W-1:0]  sel_q
);

    logic [CODE_W-1:0] eff_code;
    logic [SEL_W-1:0]  sel_d;
    src_e              src_d;

    // Form the effective code and clamp it to the existing stages.
    always_comb begin
        eff_code = ratio_code;
        eff_code[CODE_W-1] = ratio_code[CODE_W-1] & ~mode_ext;
        src_d = mode_ext ? SRC_EXT : SRC_BASE;
        if (int'(eff_code) > int'(N_DECADES)) begin
            sel_d = SEL_W'(N_DECADES);
        end else begin
            sel_d = SEL_W'(eff_code);
        end
    end

    // Latch the configuration at reset or on a load request.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            src_q <= src_d;
            sel_q <= sel_d;
        end
    end

    p_cfg_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(sel_q) && $stable(src_q)));

    p_ext_top_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (src_q == SRC_EXT) |-> (int'(sel_q) < 4));

endmodule

// File: rtl/decade_timebase.sv
// Programmable decade time base divider (top level).
// A prescaler divides ref_tick by PRE_DIV. The mode picks the base strobe
// or ext_tick as the input strobe. N_DECADES BCD stages count that strobe.
// The output pulse is the carry into the selected stage, registered for
// one cycle. hold parks every stage at nine and blocks the output.
// Settings are taken up only on a pulse or while hold is high.
module decade_timebase
    import tbd_pkg::*;
#(
    parameter int unsigned PRE_DIV   = 10,
    parameter int unsigned N_DECADES = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              ext_tick,
    input  logic              mode_ext,
    input  logic [CODE_W-1:0] ratio_code,
    input  logic              hold,
    output logic              tb_pulse
);

    localparam int unsigned SEL_W = $clog2(N_DECADES + 1);

    logic                 base_tick;
    logic                 strobe;
    logic [N_DECADES:0]   carry;
    logic [N_DECADES-1:0] at_max;
    bcd_t                 digit [N_DECADES];
    logic                 fire;
    logic                 cfg_load;
    logic                 all_zero;
    src_e                 src_q;
    logic [SEL_W-1:0]     sel_q;
    logic                 pulse_q;

    tbd_prescaler #(
        .PRE_DIV (PRE_DIV)
    ) presc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_tick  (ref_tick),
        .out_tick (base_tick)
    );

    tbd_cfg #(
        .N_DECADES (N_DECADES),
        .SEL_W     (SEL_W)
    ) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (cfg_load),
        .mode_ext   (mode_ext),
        .ratio_code (ratio_code),
        .src_q      (src_q),
        .sel_q      (sel_q)
    );

    assign strobe   = (src_q == SRC_EXT) ? ext_tick : base_tick;
    assign carry[0] = strobe;

    genvar gi;
    generate
        for (gi = 0; gi < N_DECADES; gi++) begin : g_decade
            tbd_bcd_stage stage_i (
                .clk    (clk),
                .rst_n  (rst_n),
                .park   (hold),
                .clear  (fire),
                .inc    (carry[gi]),
                .digit  (digit[gi]),
                .at_max (at_max[gi])
            );
            assign carry[gi+1] = carry[gi] & at_max[gi];
        end
    endgenerate

    assign fire     = carry[sel_q] & ~hold;
    assign cfg_load = hold | fire;
    assign tb_pulse = pulse_q;

    // Register the terminal-count strobe as the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= fire;
        end
    end

    // Flag a fully cleared interval counter, used by the checks below.
    always_comb begin
        all_zero = 1'b1;
        for (int i = 0; i < N_DECADES; i++) begin
            if (digit[i] != '0) all_zero = 1'b0;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!tb_pulse && all_zero));

    p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !tb_pulse);

    p_hold_parks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (&at_max));

    p_restart_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tb_pulse |-> all_zero);

    p_pulse_needs_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> !tb_pulse);

endmodule

// File: tb/decade_timebase_tb_top.sv
// Bench for decade_timebase. An arithmetic model (prescaler modulo count,
// interval count against 10^code) predicts tb_pulse every cycle.
module decade_timebase_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ref_tick;
    logic       ext_tick;
    logic       mode_ext;
    logic [2:0] ratio_code;
    logic       hold;
    logic       tb_pulse;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // Model state.
    int     m_pc;
    longint m_cnt;
    longint m_div;
    bit     m_src;
    logic   m_exp;

    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    decade_timebase dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick   (ref_tick),
        .ext_tick   (ext_tick),
        .mode_ext   (mode_ext),
        .ratio_code (ratio_code),
        .hold       (hold),
        .tb_pulse   (tb_pulse)
    );

    function automatic longint ratio_of(input logic [2:0] code, input logic mode);
        longint d = 1;
        int e = mode ? int'(code[1:0]) : int'(code);
        for (int k = 0; k < e; k++) d = d * 10;
        return d;
    endfunction

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: tb_pulse=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one cycle of inputs, advance the model and compare.
    task automatic step(input logic r, input logic e, input string tag);
        bit mtick;
        bit strobe;
        ref_tick = r;
        ext_tick = e;
        @(posedge clk);
        @(negedge clk);
        if (!rst_n) begin
            m_pc  = 0;
            m_cnt = 0;
            m_src = mode_ext;
            m_div = ratio_of(ratio_code, mode_ext);
            m_exp = 1'b0;
        end else begin
            mtick = r && (m_pc == 9);
            if (r) m_pc = (m_pc == 9) ? 0 : m_pc + 1;
            strobe = m_src ? e : mtick;
            m_exp = 1'b0;
            if (hold) begin
                m_src = mode_ext;
                m_div = ratio_of(ratio_code, mode_ext);
                m_cnt = m_div - 1;
            end else if (strobe) begin
                if (m_cnt + 1 == m_div) begin
                    m_exp = 1'b1;
                    m_cnt = 0;
                    m_src = mode_ext;
                    m_div = ratio_of(ratio_code, mode_ext);
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
        end
        check(tb_pulse, m_exp, tag);
    endtask

    task automatic rnd_steps(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1], lfsr[0] | lfsr[5], tag);
        end
    endtask

    task automatic do_hold(input string tag);
        hold = 1'b1;
        step(1'b0, 1'b0, tag);
        hold = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; ref_tick = 1'b0; ext_tick = 1'b0;
        mode_ext = 1'b0; ratio_code = 3'd0; hold = 1'b0;
        m_pc = 0; m_cnt = 0; m_div = 1; m_src = 1'b0; m_exp = 1'b0;
        @(negedge clk);
        // R1: reset state, strobes ignored while in reset.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, "R1");
        rst_n = 1'b1;

        // R2 R4: base source, code 0: a pulse per ten reference strobes.
        for (int i = 0; i < 60; i++) step(1'b1, 1'b0, "R2");
        rnd_steps(60, "R2");

        // R4: base source, code 1.
        ratio_code = 3'd1;
        do_hold("R4");
        for (int i = 0; i < 400; i++) step(1'b1, 1'b1, "R4");

        // R3 R4 R8: external source, codes 0..3, sparse strobes.
        mode_ext = 1'b1;
        for (int c = 0; c < 4; c++) begin
            longint d = ratio_of(3'(c), 1'b1);
            ratio_code = 3'(c);
            do_hold("R3 R4");
            rnd_steps(int'(d) * 3 + 50, "R3 R4 R8");
        end

        // R6: top bit ignored in external mode.
        for (int c = 4; c < 8; c++) begin
            longint d = ratio_of(3'(c), 1'b1);
            ratio_code = 3'(c);
            do_hold("R6");
            rnd_steps(int'(d) * 3 + 50, "R6");
        end

        // R9: change code mid-interval, old ratio finishes first.
        ratio_code = 3'd2;
        do_hold("R9");
        for (int i = 0; i < 150; i++) step(1'b0, 1'b1, "R9");
        ratio_code = 3'd1;
        for (int i = 0; i < 80; i++) step(1'b0, 1'b1, "R9");
        mode_ext = 1'b0;
        ratio_code = 3'd0;
        for (int i = 0; i < 80; i++) step(1'b1, 1'b1, "R9");

        // R7: long hold with strobes present, then immediate pulse.
        mode_ext = 1'b1;
        ratio_code = 3'd2;
        hold = 1'b1;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b1, "R7");
        hold = 1'b0;
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, "R7");
        for (int i = 0; i < 120; i++) step(1'b0, 1'b1, "R7");

        // R7 R5: largest ratio, first pulse right after release.
        mode_ext = 1'b0;
        ratio_code = 3'd7;
        do_hold("R7 R5");
        for (int i = 0; i < 300; i++) step(1'b1, 1'b0, "R7 R5");

        // R5: full 10^4 interval of base strobes.
        ratio_code = 3'd4;
        do_hold("R5");
        for (int i = 0; i < 100_120; i++) step(1'b1, 1'b0, "R5");

        // R1: mid-run reset.
        rst_n = 1'b0;
        step(1'b1, 1'b1, "R1");
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0, "R1");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule